// File: doc/BRIEF.md
# Ethernet Transmit Preamble Inserter

This block sits ahead of the transmit MAC byte path. Every outgoing frame gets a preamble in front of it. By default the block builds the preamble itself: seven 0x55 bytes and then the 0xD5 start-of-frame delimiter. The frame bytes follow, in order, one per clock.

A frame can carry its own preamble instead. This needs two things: the global enable must be set, and the frame's custom flag must be high on its first beat. The block then takes the frame's eight leading bytes and sends them as the preamble. These bytes sit in front of the destination address. When the reduced-pin-count (RMII) mode input is high, only the generated preamble may leave the block. In that mode the eight leading bytes of a custom-requested frame are still consumed, but they are thrown away and the standard sequence goes out in their place.

A custom-requested frame that ends before its eighth byte is dropped without emitting anything, and a one-cycle error pulse is raised. After each frame the block keeps the output silent for a minimum inter-frame gap before it starts the next preamble. FCS generation, padding and line encoding belong to other blocks.

Top module: `tx_preamble_insert`

## Requirements
- R1: After reset and before any input, `out_valid`, `in_ready` and `drop_err` are all 0.
- R2: A frame that does not request a custom preamble is emitted as seven 0x55 bytes, one 0xD5 byte, then all of its input bytes in order. The output bytes are on consecutive cycles when input is continuous, and `out_last` is set only on the final input byte.
- R3: A custom-requested frame (`cust_en`=1 and `in_custom`=1 on the first beat) with `rmii_mode`=0 and more than eight bytes is emitted as its input bytes unchanged. The first eight of them serve as the preamble, and `out_last` is set on the final byte.
- R4: With `cust_en`=0 the `in_custom` flag has no effect: the frame is handled exactly as in R2, with every input byte forwarded after the generated preamble.
- R5: With `rmii_mode`=1, a custom-requested frame has its first eight input bytes discarded. The output is the standard preamble followed by input bytes nine onward.
- R6: A custom-requested frame whose last marker arrives on one of its first seven bytes produces no output byte. `drop_err` is high for exactly one cycle, the cycle after the last byte is accepted.
- R7: `in_ready` stays low while the generated preamble is being produced, so a standard frame's first byte waits at least eight cycles before it is accepted. `in_ready` is low in the first cycle any preamble byte appears on the output.
- R8: Between an output byte with `out_last` and the next output byte with `out_valid`, at least 12 cycles pass with `out_valid` low.
- R9: A custom-requested frame of exactly eight bytes with `rmii_mode`=0 is emitted as those eight bytes, with `out_last` on the eighth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cust_en | input | 1 | Global permission for frame-supplied preambles |
| rmii_mode | input | 1 | High in RMII operation; forces the generated preamble |
| in_data | input | 8 | Input frame byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the last byte of a frame |
| in_custom | input | 1 | Per-frame custom preamble request, sampled with `in_first` |
| out_data | output | 8 | Byte toward the PHY interface |
| out_valid | output | 1 | Output byte present |
| out_last | output | 1 | Marks the final output byte of a frame |
| drop_err | output | 1 | One-cycle pulse when a short custom frame is dropped |

## Verification
The assertions take the input stream to be well formed. A frame's first beat carries `in_first`, and its last carries `in_last`. Once `in_valid` is raised it stays high with stable data until the byte is accepted. The mode inputs change only while no frame is in progress.

The stimulus drives each frame back to back, with no bubbles. It changes `cust_en`, `rmii_mode` and `in_custom` only between frames, and it sends the next frame as soon as the previous one has left the block. Every combination of the three controls is swept against frame lengths from 1 to 20 bytes, so the inter-frame gap logic is always exercised.

// File: rtl/txp_pkg.sv
package txp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_GEN,
      ST_EMIT,
      ST_PAY,
      ST_GAP
   } txp_state_e;
endpackage

// File: rtl/txp_pre_gen.sv
module txp_pre_gen #(
   parameter int          PRE_LEN  = 8,
   parameter logic [7:0]  PRE_BYTE = 8'h55,
   parameter logic [7:0]  SFD_BYTE = 8'hD5,
   parameter int          IDX_W    = 3
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       byte_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PRE_LEN - 1);

   // delimiter closes the sequence, filler everywhere else
   assign byte_o = (idx == LAST_IDX) ? SFD_BYTE : PRE_BYTE;
endmodule

// File: rtl/txp_capture.sv
module txp_capture #(
   parameter int PRE_LEN = 8,
   parameter int IDX_W   = 3,
   parameter bit ENABLE  = 1'b1
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);
   generate
      if (ENABLE) begin : g_store
         logic [7:0] slot_q [PRE_LEN];
         always_ff @(posedge clk) begin
            if (wr_en) slot_q[wr_idx] <= wr_data;
         end
         assign rd_data = slot_q[rd_idx];
      end else begin : g_none
         assign rd_data = 8'h00;
      end
   endgenerate
endmodule

// File: rtl/txp_gap_timer.sv
module txp_gap_timer #(
   parameter int GAP_BYTES = 12,
   parameter int CNT_W     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam logic [CNT_W-1:0] END_CNT = CNT_W'(GAP_BYTES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (cnt_q != END_CNT) cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == END_CNT);

   p_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done || !run);
endmodule

// File: rtl/tx_preamble_insert.sv
module tx_preamble_insert #(
   parameter int         PRE_LEN        = 8,
   parameter int         GAP_BYTES      = 12,
   parameter logic [7:0] PRE_BYTE       = 8'h55,
   parameter logic [7:0] SFD_BYTE       = 8'hD5,
   parameter bit         CUSTOM_SUPPORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cust_en,
   input  logic       rmii_mode,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic       in_first,
   input  logic       in_last,
   input  logic       in_custom,
   output logic [7:0] out_data,
   output logic       out_valid,
   output logic       out_last,
   output logic       drop_err
);
   import txp_pkg::*;

   localparam int               IDX_W    = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
   localparam int               GAP_W    = $clog2(GAP_BYTES + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PRE_LEN - 1);

   generate
      if (PRE_LEN < 2) begin : g_bad_len
         $error("tx_preamble_insert: PRE_LEN must be at least 2");
      end
      if (GAP_BYTES < 1) begin : g_bad_gap
         $error("tx_preamble_insert: GAP_BYTES must be at least 1");
      end
   endgenerate

   txp_state_e       st_q, st_n;
   logic [IDX_W-1:0] idx_q, idx_n;
   logic             ends_q, ends_n;   // frame ends inside its preamble
   logic             keep_q, keep_n;   // captured bytes become the preamble
   logic             cap_we, gap_run, gap_done, ready_c;
   logic [7:0]       gen_byte, cap_byte;
   logic [7:0]       od_n;
   logic             ov_n, ol_n, err_n;
   logic [7:0]       od_q;
   logic             ov_q, ol_q, err_q;

   txp_pre_gen #(.PRE_LEN(PRE_LEN), .PRE_BYTE(PRE_BYTE), .SFD_BYTE(SFD_BYTE), .IDX_W(IDX_W))
      u_gen (.idx(idx_q), .byte_o(gen_byte));

   txp_capture #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W), .ENABLE(CUSTOM_SUPPORT))
      u_cap (.clk(clk), .wr_en(cap_we), .wr_idx(idx_q), .wr_data(in_data),
             .rd_idx(idx_q), .rd_data(cap_byte));

   txp_gap_timer #(.GAP_BYTES(GAP_BYTES), .CNT_W(GAP_W))
      u_gap (.clk(clk), .rst_n(rst_n), .run(gap_run), .done(gap_done));

   always_comb begin
      st_n    = st_q;
      idx_n   = idx_q;
      ends_n  = ends_q;
      keep_n  = keep_q;
      cap_we  = 1'b0;
      ready_c = 1'b0;
      gap_run = 1'b0;
      ov_n    = 1'b0;
      ol_n    = 1'b0;
      od_n    = od_q;
      err_n   = 1'b0;
      case (st_q)
         ST_IDLE: begin
            ends_n = 1'b0;
            idx_n  = '0;
            if (in_valid && in_first) begin
               if (CUSTOM_SUPPORT && cust_en && in_custom) begin
                  st_n   = ST_COLLECT;
                  keep_n = !rmii_mode;
               end else begin
                  st_n   = ST_GEN;
                  keep_n = 1'b0;
               end
            end
         end
         ST_COLLECT: begin
            ready_c = 1'b1;
            if (in_valid) begin
               cap_we = 1'b1;
               if (idx_q == LAST_IDX) begin
                  ends_n = in_last;
                  idx_n  = '0;
                  st_n   = keep_q ? ST_EMIT : ST_GEN;
               end else if (in_last) begin
                  err_n = 1'b1;
                  st_n  = ST_IDLE;
               end else begin
                  idx_n = idx_q + 1'b1;
               end
            end
         end
         ST_GEN, ST_EMIT: begin
            ov_n = 1'b1;
            od_n = (st_q == ST_EMIT) ? cap_byte : gen_byte;
            ol_n = (idx_q == LAST_IDX) && ends_q;
            if (idx_q == LAST_IDX) begin
               idx_n = '0;
               st_n  = ends_q ? ST_GAP : ST_PAY;
            end else begin
               idx_n = idx_q + 1'b1;
            end
         end
         ST_PAY: begin
            ready_c = 1'b1;
            if (in_valid) begin
               ov_n = 1'b1;
               od_n = in_data;
               ol_n = in_last;
               if (in_last) st_n = ST_GAP;
            end
         end
         ST_GAP: begin
            gap_run = 1'b1;
            if (gap_done) st_n = ST_IDLE;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         ends_q <= 1'b0;
         keep_q <= 1'b0;
         od_q   <= '0;
         ov_q   <= 1'b0;
         ol_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_n;
         idx_q  <= idx_n;
         ends_q <= ends_n;
         keep_q <= keep_n;
         od_q   <= od_n;
         ov_q   <= ov_n;
         ol_q   <= ol_n;
         err_q  <= err_n;
      end
   end

   assign in_ready  = ready_c;
   assign out_data  = od_q;
   assign out_valid = ov_q;
   assign out_last  = ol_q;
   assign drop_err  = err_q;

   // silent cycles since the most recent out_last, saturating
   logic [GAP_W-1:0] quiet_q;
   always_ff @(posedge clk) begin
      if (!rst_n) quiet_q <= GAP_W'(GAP_BYTES);
      else if (ol_q) quiet_q <= '0;
      else if (!ov_q && quiet_q != GAP_W'(GAP_BYTES)) quiet_q <= quiet_q + 1'b1;
   end

   p_gap_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (quiet_q >= GAP_W'(GAP_BYTES)));

   p_last_then_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);

   p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_err |=> !drop_err);

   p_err_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_err |-> !out_valid);

   p_preamble_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> !in_ready);
endmodule

// File: tb/tb_tx_preamble_insert.sv
module tb_tx_preamble_insert;
   localparam int PRE = 8;
   localparam int GAP = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cust_en = 1'b0, rmii_mode = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_custom = 1'b0;
   logic       in_ready;
   logic [7:0] out_data;
   logic       out_valid, out_last, drop_err;

   tx_preamble_insert dut (
      .clk(clk), .rst_n(rst_n), .cust_en(cust_en), .rmii_mode(rmii_mode),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .in_first(in_first), .in_last(in_last), .in_custom(in_custom),
      .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
      .drop_err(drop_err));

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // output monitor
   logic [7:0] got_d [64];
   bit         got_l [64];
   int         got_n = 0;
   bit         got_done = 1'b0;
   int         err_hi = 0;
   int         idle_run = 0;
   bit         seen_last = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (drop_err) err_hi++;
         if (out_valid) begin
            if (seen_last) chk(idle_run >= GAP, "R8", "idle cycles between frames", idle_run, GAP);
            seen_last = 1'b0;
            if (got_n < 64) begin
               got_d[got_n] = out_data;
               got_l[got_n] = out_last;
            end
            got_n++;
            if (out_last) begin
               got_done  = 1'b1;
               seen_last = 1'b1;
            end
            idle_run = 0;
         end else begin
            idle_run++;
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic run_frame(input int len, input bit ce, input bit cu, input bit rm, input int fid);
      logic [7:0] inb [32];
      logic [7:0] expd [40];
      bit         expl [40];
      int         exp_n, e0, waited, pos;
      bit         req, drop;
      string      tag;
      for (int i = 0; i < len; i++) inb[i] = 8'(fid * 7 + i * 13 + 1);
      req  = ce && cu;
      drop = req && (len < PRE);
      exp_n = 0;
      if (req && !rm) begin
         for (int i = 0; i < len; i++) begin expd[exp_n] = inb[i]; exp_n++; end
      end else begin
         for (int i = 0; i < PRE; i++) begin
            expd[exp_n] = (i == PRE - 1) ? 8'hD5 : 8'h55; exp_n++;
         end
         for (int i = (req ? PRE : 0); i < len; i++) begin expd[exp_n] = inb[i]; exp_n++; end
      end
      for (int i = 0; i < exp_n; i++) expl[i] = (i == exp_n - 1);
      if (drop)               tag = "R6";
      else if (req && !rm)    tag = (len == PRE) ? "R9" : "R3";
      else if (req && rm)     tag = "R5";
      else if (cu && !ce)     tag = "R4";
      else                    tag = "R2";

      cust_en   = ce;
      rmii_mode = rm;
      got_n     = 0;
      got_done  = 1'b0;
      e0        = err_hi;
      waited    = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid  = 1'b1;
         in_data   = inb[i];
         in_first  = (i == 0);
         in_last   = (i == len - 1);
         in_custom = cu;
         #1;
         while (!in_ready) begin
            @(negedge clk);
            #1;
            if (i == 0) waited++;
         end
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_custom = 1'b0;
      if (!req) chk(waited >= PRE, "R7", "first beat stall cycles", waited, PRE);

      if (drop) begin
         repeat (4) @(negedge clk);
         #2;
         chk(got_n == 0, "R6", "bytes from dropped frame", got_n, 0);
         chk(err_hi - e0 == 1, "R6", "drop_err high cycles", err_hi - e0, 1);
      end else begin
         pos = 0;
         while (!got_done && pos < 80) begin
            @(negedge clk);
            #2;
            pos++;
         end
         chk(got_done, tag, "frame completed", got_done, 1);
         chk(got_n == exp_n, tag, "output length", got_n, exp_n);
         chk(err_hi == e0, tag, "no drop pulse", err_hi - e0, 0);
         for (int k = 0; k < exp_n && k < got_n; k++) begin
            chk(got_d[k] == expd[k], tag, $sformatf("byte %0d", k), got_d[k], expd[k]);
            chk(got_l[k] == expl[k], tag, $sformatf("last flag %0d", k), got_l[k], expl[k]);
         end
      end
   endtask

   initial begin
      int fid;
      fid = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
      chk(drop_err == 1'b0, "R1", "drop_err after reset", drop_err, 0);
      for (int rm = 0; rm < 2; rm++)
         for (int ce = 0; ce < 2; ce++)
            for (int cu = 0; cu < 2; cu++)
               for (int len = 1; len <= 20; len++) begin
                  run_frame(len, ce[0], cu[0], rm[0], fid);
                  fid++;
               end
      repeat (20) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule